// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a 16-bit up/down timer paired with a 16-bit register that holds either a reload value or a captured count. A set of level inputs picks the operating mode. The timer can run as an auto-reload up counter, or as an up/down counter whose direction follows an external pin. It can also capture the running count on an edge of that pin, or generate a square wave on the count pin.

The timer advances on a machine-cycle tick. In clock-out mode it advances on a faster oscillator-rate tick instead, which the system supplies at six times the machine-cycle rate. If counter operation is selected, it advances on falling edges of the count pin instead of either tick. Two sticky flags report overflow and external-pin events, and software clears them with one-cycle clear pulses. Software loads the count and the reload register through write strobes.

The modes are checked in a fixed order. Clock-out wins first. Next, either baud-clock select stops all counting. After that, capture is chosen over reload. When a reload is chosen, up/down operation is chosen over plain up counting.

Top module: `mtc_timer16`

## Requirements
- R1: While `run_en` is low, the count, the reload register and both flags do not change on ticks or pin edges. Only software writes can change the count or the reload register.
- R2: Mode priority, highest first:
  - clock-out (`clkout_en`);
  - baud hold (`baud_rx_sel` or `baud_tx_sel`), which stops all counting;
  - capture (`cap_sel`);
  - up/down (`updown_en`);
  - plain auto-reload.
- R3: When `ctr_sel` is low, the count advances once per cycle in which `cyc_tick` is high. When `ctr_sel` is high, it advances once per falling edge of `cnt_pin_in` (the pin was high in the previous cycle and is low now), and `cyc_tick` is ignored.
- R4: In auto-reload mode, a step taken at 0xFFFF loads the reload register into the count and sets `ovf_flag`. Any other step adds one.
- R5: In auto-reload mode with `ext_en` high, a falling edge on `ext_pin_in` loads the reload register into the count and sets `ext_flag`. With `ext_en` low, such an edge has no effect.
- R6: In capture mode, a falling edge on `ext_pin_in` with `ext_en` high copies the count into the reload register and sets `ext_flag`. A step at 0xFFFF wraps the count to 0x0000 and sets `ovf_flag`, and the reload register is left unchanged.
- R7: In up/down mode with `ext_pin_in` high, the count steps up. A step at 0xFFFF loads the reload register, sets `ovf_flag` and toggles `ext_flag`.
- R8: In up/down mode with `ext_pin_in` low, the count steps down. When the decremented value equals the reload register, the count becomes 0xFFFF instead, `ovf_flag` is set and `ext_flag` toggles. In this mode an edge on `ext_pin_in` never sets `ext_flag`.
- R9: In clock-out mode with `ctr_sel` low:
  - `clk_out_oe` is high;
  - the count steps on `fast_tick` and ignores `cyc_tick`;
  - a step at 0xFFFF loads the reload register and toggles `clk_out`;
  - `ovf_flag` is not set.
- R10: In clock-out mode, a falling edge on `ext_pin_in` with `ext_en` high sets `ext_flag`. While `cap_sel` is high, the count holds.
- R11: Each flag stays set until its clear pulse (`ovf_clr`, `ext_clr`). A setting event in the same cycle as the clear leaves the flag set.
- R12: After reset the count, the reload register, both flags and `clk_out` are zero. A write strobe sets the count or the reload register on the next edge, and it takes precedence over counting, reload and capture in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Machine-cycle count enable |
| fast_tick | input | 1 | Oscillator-rate count enable used in clock-out mode |
| cnt_pin_in | input | 1 | Count pin level |
| ext_pin_in | input | 1 | External pin level (edge event, or up/down direction) |
| run_en | input | 1 | Run enable |
| ctr_sel | input | 1 | Count on count-pin falling edges instead of ticks |
| cap_sel | input | 1 | Capture select (halts counting in clock-out mode) |
| ext_en | input | 1 | Enable external-pin edge events |
| baud_rx_sel | input | 1 | Receive baud-clock select (suppresses counting) |
| baud_tx_sel | input | 1 | Transmit baud-clock select (suppresses counting) |
| clkout_en | input | 1 | Clock-out mode enable |
| updown_en | input | 1 | Up/down mode enable |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write data |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | 16 | Reload register write data |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| ext_clr | input | 1 | External flag clear pulse |
| count_q | output | 16 | Current count |
| rld_q | output | 16 | Reload / capture register |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external flag |
| clk_out | output | 1 | Clock-out drive for the count pin |
| clk_out_oe | output | 1 | Clock-out drive enable |

## Verification
The count is started just below 0xFFFF and ticked across the wrap in each mode. This shows whether the wrap loads the reload value, wraps to zero, or loads all-ones on a down-count match, and which flag moves with it. The same external-pin falling edge is applied in the reload, capture, up/down and clock-out modes, and with `ext_en` low. This shows the reload, capture, flag-only and ignored responses. Conflicting mode selects are enabled together, and ticks on `cyc_tick` and `fast_tick` are applied in turn, to expose a wrong priority order or the wrong count source.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   typedef enum logic [2:0] {
      MD_IDLE    = 3'd0,
      MD_BAUD    = 3'd1,
      MD_RELOAD  = 3'd2,
      MD_UPDOWN  = 3'd3,
      MD_CAPTURE = 3'd4,
      MD_CLKOUT  = 3'd5
   } mtc_mode_e;

   typedef struct packed {
      logic ovf;      // sets overflow flag
      logic ext_set;  // sets external flag
      logic ext_tgl;  // toggles external flag
      logic pin_tgl;  // toggles clock-out drive
   } mtc_evt_t;

endpackage

// File: rtl/mtc_pin_edge.sv
module mtc_pin_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("mtc_pin_edge: SYNC_STAGES out of range");
   end

   logic pin_s;
   logic prev_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign pin_s = pin;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else begin
            sh_q[0] <= pin;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               sh_q[i] <= sh_q[i-1];
            end
         end
      end
      assign pin_s = sh_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;
   end

   assign fall = prev_q & ~pin_s;

endmodule

// File: rtl/mtc_mode_dec.sv
module mtc_mode_dec
   import mtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run_en,
   input  logic      ctr_sel,
   input  logic      cap_sel,
   input  logic      baud_rx_sel,
   input  logic      baud_tx_sel,
   input  logic      clkout_en,
   input  logic      updown_en,
   input  logic      cyc_tick,
   input  logic      fast_tick,
   input  logic      cnt_fall,
   output mtc_mode_e mode,
   output logic      step,
   output logic      pin_oe
);

   always_comb begin
      if (!run_en)                        mode = MD_IDLE;
      else if (clkout_en)                 mode = MD_CLKOUT;
      else if (baud_rx_sel | baud_tx_sel) mode = MD_BAUD;
      else if (cap_sel)                   mode = MD_CAPTURE;
      else if (updown_en)                 mode = MD_UPDOWN;
      else                                mode = MD_RELOAD;
   end

   always_comb begin
      unique case (mode)
         MD_CLKOUT:  step = ~cap_sel & (ctr_sel ? cnt_fall : fast_tick);
         MD_RELOAD,
         MD_UPDOWN,
         MD_CAPTURE: step = ctr_sel ? cnt_fall : cyc_tick;
         default:    step = 1'b0;
      endcase
   end

   assign pin_oe = (mode == MD_CLKOUT) & ~ctr_sel;

   AST_NO_STEP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en || ((baud_rx_sel || baud_tx_sel) && !clkout_en)) |-> !step) // R1
      else $error("step while stopped");

endmodule

// File: rtl/mtc_count_core.sv
module mtc_count_core
   import mtc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mtc_mode_e        mode,
   input  logic             step,
   input  logic             up_dir,
   input  logic             ext_fall,
   input  logic             ext_en,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             rld_wr,
   input  logic [CNT_W-1:0] rld_wdata,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] rld_q,
   output mtc_evt_t         evt
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] ZERO     = '0;

   logic [CNT_W-1:0] cnt_n, rld_n, inc_v, dec_v;
   logic             at_top, ext_hit;

   assign inc_v   = count_q + 1'b1;
   assign dec_v   = count_q - 1'b1;
   assign at_top  = (count_q == ALL_ONES);
   assign ext_hit = ext_fall & ext_en;

   always_comb begin
      cnt_n = count_q;
      rld_n = rld_q;
      evt   = '0;
      unique case (mode)
         MD_RELOAD: begin
            if (ext_hit) begin
               cnt_n       = rld_q;
               evt.ext_set = 1'b1;
            end else if (step) begin
               if (at_top) begin
                  cnt_n   = rld_q;
                  evt.ovf = 1'b1;
               end else begin
                  cnt_n = inc_v;
               end
            end
         end
         MD_CAPTURE: begin
            if (step) begin
               cnt_n   = inc_v;
               evt.ovf = at_top;
            end
            if (ext_hit) begin
               rld_n       = count_q;
               evt.ext_set = 1'b1;
            end
         end
         MD_UPDOWN: begin
            if (step) begin
               if (up_dir) begin
                  if (at_top) begin
                     cnt_n       = rld_q;
                     evt.ovf     = 1'b1;
                     evt.ext_tgl = 1'b1;
                  end else begin
                     cnt_n = inc_v;
                  end
               end else begin
                  if (dec_v == rld_q) begin
                     cnt_n       = ALL_ONES;
                     evt.ovf     = 1'b1;
                     evt.ext_tgl = 1'b1;
                  end else begin
                     cnt_n = dec_v;
                  end
               end
            end
         end
         MD_CLKOUT: begin
            if (ext_hit) evt.ext_set = 1'b1;
            if (step) begin
               if (at_top) begin
                  cnt_n       = rld_q;
                  evt.pin_tgl = 1'b1;
               end else begin
                  cnt_n = inc_v;
               end
            end
         end
         default: ;
      endcase
      if (cnt_wr) cnt_n = cnt_wdata;
      if (rld_wr) rld_n = rld_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= ZERO;
         rld_q   <= ZERO;
      end else begin
         count_q <= cnt_n;
         rld_q   <= rld_n;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_IDLE && !cnt_wr) |=> $stable(count_q)) // R1
      else $error("count moved while idle");

   AST_RELOAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_RELOAD && step && !ext_hit && at_top && !cnt_wr)
      |=> (count_q == $past(rld_q))) // R4
      else $error("reload wrap wrong");

   AST_CAPTURE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_CAPTURE && step && at_top && !cnt_wr)
      |=> (count_q == ZERO)) // R6
      else $error("capture wrap wrong");

   AST_DOWN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_UPDOWN && !up_dir && evt.ovf && !cnt_wr)
      |=> (count_q == ALL_ONES)) // R8
      else $error("down match did not load all-ones");

endmodule

// File: rtl/mtc_flag_unit.sv
module mtc_flag_unit
   import mtc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  mtc_evt_t evt,
   input  logic     pin_oe,
   input  logic     ovf_clr,
   input  logic     ext_clr,
   output logic     ovf_q,
   output logic     ext_q,
   output logic     clk_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         ext_q <= 1'b0;
         clk_q <= 1'b0;
      end else begin
         ovf_q <= (ovf_q & ~ovf_clr) | evt.ovf;
         ext_q <= ((ext_q & ~ext_clr) | evt.ext_set) ^ evt.ext_tgl;
         clk_q <= clk_q ^ (evt.pin_tgl & pin_oe);
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q) // R11
      else $error("overflow flag dropped");

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      evt.ovf |=> ovf_q) // R11
      else $error("overflow flag not set");

   AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt.pin_tgl && pin_oe) |=> $stable(clk_q)) // R9
      else $error("clock-out drive moved without wrap");

endmodule

// File: rtl/mtc_timer16.sv
module mtc_timer16
   import mtc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_tick,
   input  logic             fast_tick,
   input  logic             cnt_pin_in,
   input  logic             ext_pin_in,
   input  logic             run_en,
   input  logic             ctr_sel,
   input  logic             cap_sel,
   input  logic             ext_en,
   input  logic             baud_rx_sel,
   input  logic             baud_tx_sel,
   input  logic             clkout_en,
   input  logic             updown_en,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             rld_wr,
   input  logic [CNT_W-1:0] rld_wdata,
   input  logic             ovf_clr,
   input  logic             ext_clr,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] rld_q,
   output logic             ovf_flag,
   output logic             ext_flag,
   output logic             clk_out,
   output logic             clk_out_oe
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("mtc_timer16: CNT_W out of range");
   end

   mtc_mode_e mode;
   mtc_evt_t  evt;
   logic      cnt_fall, ext_fall, step;

   mtc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cnt_edge (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin_in), .fall(cnt_fall)
   );

   mtc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin_in), .fall(ext_fall)
   );

   mtc_mode_dec u_dec (
      .clk(clk), .rst_n(rst_n),
      .run_en(run_en), .ctr_sel(ctr_sel), .cap_sel(cap_sel),
      .baud_rx_sel(baud_rx_sel), .baud_tx_sel(baud_tx_sel),
      .clkout_en(clkout_en), .updown_en(updown_en),
      .cyc_tick(cyc_tick), .fast_tick(fast_tick), .cnt_fall(cnt_fall),
      .mode(mode), .step(step), .pin_oe(clk_out_oe)
   );

   mtc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .mode(mode), .step(step), .up_dir(ext_pin_in),
      .ext_fall(ext_fall), .ext_en(ext_en),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .rld_wr(rld_wr), .rld_wdata(rld_wdata),
      .count_q(count_q), .rld_q(rld_q), .evt(evt)
   );

   mtc_flag_unit u_flags (
      .clk(clk), .rst_n(rst_n), .evt(evt), .pin_oe(clk_out_oe),
      .ovf_clr(ovf_clr), .ext_clr(ext_clr),
      .ovf_q(ovf_flag), .ext_q(ext_flag), .clk_q(clk_out)
   );

   AST_UPDOWN_NO_EXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_UPDOWN && !ext_flag && !evt.ext_tgl) |=> !ext_flag) // R8
      else $error("external flag set by pin in up/down mode");

endmodule

// File: tb/sim_mtc_timer16.sv
`timescale 1ns/1ps
module sim_mtc_timer16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_tick = 0, fast_tick = 0, cnt_pin_in = 1, ext_pin_in = 1;
   logic        run_en = 0, ctr_sel = 0, cap_sel = 0, ext_en = 0;
   logic        baud_rx_sel = 0, baud_tx_sel = 0, clkout_en = 0, updown_en = 0;
   logic        cnt_wr = 0, rld_wr = 0, ovf_clr = 0, ext_clr = 0;
   logic [15:0] cnt_wdata = 0, rld_wdata = 0;
   logic [15:0] count_q, rld_q;
   logic        ovf_flag, ext_flag, clk_out, clk_out_oe;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mtc_timer16 u0 (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .fast_tick(fast_tick),
      .cnt_pin_in(cnt_pin_in), .ext_pin_in(ext_pin_in), .run_en(run_en),
      .ctr_sel(ctr_sel), .cap_sel(cap_sel), .ext_en(ext_en),
      .baud_rx_sel(baud_rx_sel), .baud_tx_sel(baud_tx_sel),
      .clkout_en(clkout_en), .updown_en(updown_en),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .rld_wr(rld_wr), .rld_wdata(rld_wdata),
      .ovf_clr(ovf_clr), .ext_clr(ext_clr), .count_q(count_q), .rld_q(rld_q),
      .ovf_flag(ovf_flag), .ext_flag(ext_flag), .clk_out(clk_out), .clk_out_oe(clk_out_oe)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // All helpers start and end at a falling edge.
   task automatic pulse_cyc(input int n);
      for (int i = 0; i < n; i++) begin
         cyc_tick = 1; @(negedge clk); cyc_tick = 0;
      end
   endtask

   task automatic pulse_fast(input int n);
      for (int i = 0; i < n; i++) begin
         fast_tick = 1; @(negedge clk); fast_tick = 0;
      end
   endtask

   task automatic write_cnt(input logic [15:0] v);
      cnt_wr = 1; cnt_wdata = v; @(negedge clk); cnt_wr = 0;
   endtask

   task automatic write_rld(input logic [15:0] v);
      rld_wr = 1; rld_wdata = v; @(negedge clk); rld_wr = 0;
   endtask

   task automatic ext_edge();
      ext_pin_in = 0; @(negedge clk); ext_pin_in = 1; @(negedge clk);
   endtask

   task automatic cnt_edge();
      cnt_pin_in = 0; @(negedge clk); cnt_pin_in = 1; @(negedge clk);
   endtask

   task automatic clr_flags();
      ovf_clr = 1; ext_clr = 1; @(negedge clk); ovf_clr = 0; ext_clr = 0;
   endtask

   task automatic t_reset();
      check("R12", "reset count", count_q, 16'h0000);
      check("R12", "reset rld", rld_q, 16'h0000);
      check("R12", "reset flags", {ovf_flag, ext_flag, clk_out}, 3'b000);
   endtask

   task automatic t_idle();
      run_en = 0; ext_en = 1;
      pulse_cyc(5);
      check("R1", "count while stopped", count_q, 16'h0000);
      ext_edge();
      check("R1", "ext flag while stopped", ext_flag, 1'b0);
   endtask

   task automatic t_write();
      write_cnt(16'hFFFD);
      write_rld(16'h1234);
      check("R12", "count write", count_q, 16'hFFFD);
      check("R12", "reload write", rld_q, 16'h1234);
   endtask

   task automatic t_reload();
      run_en = 1;
      pulse_cyc(2);
      check("R3", "timer ticks", count_q, 16'hFFFF);
      pulse_cyc(1);
      check("R4", "wrap reload", count_q, 16'h1234);
      check("R4", "ovf set", ovf_flag, 1'b1);
      check("R4", "ext untouched", ext_flag, 1'b0);
   endtask

   task automatic t_sticky();
      repeat (3) @(negedge clk);
      check("R11", "ovf held", ovf_flag, 1'b1);
      ovf_clr = 1; @(negedge clk); ovf_clr = 0;
      check("R11", "ovf cleared", ovf_flag, 1'b0);
      write_cnt(16'hFFFF);
      ovf_clr = 1; cyc_tick = 1; @(negedge clk); ovf_clr = 0; cyc_tick = 0;
      check("R11", "set beats clear", ovf_flag, 1'b1);
      clr_flags();
   endtask

   task automatic t_ext_reload();
      ext_en = 1;
      write_cnt(16'h0100);
      ext_edge();
      check("R5", "edge reload count", count_q, 16'h1234);
      check("R5", "edge ext flag", ext_flag, 1'b1);
      clr_flags();
      ext_en = 0;
      write_cnt(16'h0100);
      ext_edge();
      check("R5", "disabled edge count", count_q, 16'h0100);
      check("R5", "disabled edge flag", ext_flag, 1'b0);
   endtask

   task automatic t_counter();
      ctr_sel = 1;
      pulse_cyc(3);
      check("R3", "cyc ignored in counter", count_q, 16'h0100);
      cnt_edge();
      cnt_edge();
      check("R3", "count pin edges", count_q, 16'h0102);
      ctr_sel = 0;
   endtask

   task automatic t_capture();
      cap_sel = 1; ext_en = 1;
      write_cnt(16'h4321);
      pulse_cyc(1);
      ext_edge();
      check("R6", "captured value", rld_q, 16'h4322);
      check("R6", "capture ext flag", ext_flag, 1'b1);
      check("R6", "count kept", count_q, 16'h4322);
      write_cnt(16'hFFFF);
      pulse_cyc(1);
      check("R6", "wrap to zero", count_q, 16'h0000);
      check("R6", "ovf set", ovf_flag, 1'b1);
      check("R6", "no reload change", rld_q, 16'h4322);
      clr_flags();
      cap_sel = 0;
   endtask

   task automatic t_updown_up();
      updown_en = 1; ext_pin_in = 1;
      write_rld(16'h1000);
      write_cnt(16'hFFFF);
      pulse_cyc(1);
      check("R7", "up wrap reload", count_q, 16'h1000);
      check("R7", "up flags", {ovf_flag, ext_flag}, 2'b11);
      pulse_cyc(1);
      check("R7", "up step", count_q, 16'h1001);
      write_cnt(16'hFFFF);
      pulse_cyc(1);
      check("R7", "ext toggled back", {ovf_flag, ext_flag}, 2'b10);
   endtask

   task automatic t_updown_down();
      clr_flags();
      write_cnt(16'h1002);
      ext_pin_in = 0; @(negedge clk);
      check("R8", "pin edge ignored", {ext_flag, count_q}, {1'b0, 16'h1002});
      pulse_cyc(1);
      check("R8", "down step", {ovf_flag, count_q}, {1'b0, 16'h1001});
      pulse_cyc(1);
      check("R8", "match loads ones", count_q, 16'hFFFF);
      check("R8", "match flags", {ovf_flag, ext_flag}, 2'b11);
      pulse_cyc(1);
      check("R8", "down from ones", count_q, 16'hFFFE);
   endtask

   task automatic t_baud();
      ext_pin_in = 1; @(negedge clk);
      clr_flags();
      baud_tx_sel = 1;
      pulse_cyc(3);
      check("R2", "tx baud holds", count_q, 16'hFFFE);
      baud_tx_sel = 0; baud_rx_sel = 1;
      pulse_cyc(2);
      check("R2", "rx baud holds", count_q, 16'hFFFE);
      clkout_en = 1;
      pulse_fast(1);
      check("R2", "clock-out beats baud", count_q, 16'hFFFF);
      baud_rx_sel = 0; updown_en = 0;
   endtask

   task automatic t_clkout();
      write_rld(16'hFFFE);
      write_cnt(16'hFFFE);
      clr_flags();
      check("R9", "drive enable", clk_out_oe, 1'b1);
      pulse_fast(1);
      check("R9", "fast step", count_q, 16'hFFFF);
      pulse_fast(1);
      check("R9", "wrap reload", count_q, 16'hFFFE);
      check("R9", "pin toggled high", clk_out, 1'b1);
      check("R9", "no ovf flag", ovf_flag, 1'b0);
      pulse_cyc(2);
      check("R9", "cyc ignored", count_q, 16'hFFFE);
      pulse_fast(2);
      check("R9", "pin toggled low", clk_out, 1'b0);
   endtask

   task automatic t_clkout_ext();
      ext_en = 1;
      ext_edge();
      check("R10", "ext flag in clock-out", ext_flag, 1'b1);
      cap_sel = 1;
      pulse_fast(3);
      check("R10", "cap_sel halts", count_q, 16'hFFFE);
      clkout_en = 0;
      @(negedge clk);
   endtask

   task automatic t_prio_capture();
      updown_en = 1;
      clr_flags();
      write_cnt(16'h5555);
      ext_edge();
      check("R2", "capture beats up/down", {ext_flag, rld_q}, {1'b1, 16'h5555});
      cap_sel = 0; updown_en = 0;
   endtask

   task automatic t_write_override();
      cyc_tick = 1; cnt_wr = 1; cnt_wdata = 16'h7777;
      @(negedge clk);
      cyc_tick = 0; cnt_wr = 0;
      check("R12", "write beats tick", count_q, 16'h7777);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_write();
      t_reload();
      t_sticky();
      t_ext_reload();
      t_counter();
      t_capture();
      t_updown_up();
      t_updown_down();
      t_baud();
      t_clkout();
      t_clkout_ext();
      t_prio_capture();
      t_write_override();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule